// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

The sequencer drives the four coil phase lines of a stepper motor. A host hands it a command made of a step count and a 32-bit pattern word. The word holds eight 4-bit coil states. Drive mode and direction live entirely in that word, so the block has no built-in step tables. One-phase, two-phase and half-step drive in either direction are just different words. For example, the half-step forward word is 0x98C46231 and the one-phase forward word is 0x84218421.

Each step puts the next coil state on the outputs and holds it for a fixed number of prescaler ticks. The prescaler divides the clock by a programmable ratio. After the eighth state the nibble pointer reloads from the stored word, so the sequence rotates until the step count runs out. At that point a one-cycle done pulse is raised. An abort input drops the running command at any time.

Top module: `stp_phase_seq`

## Requirements
- R1: After reset, `phase_out` is 0, `done` is 0 and `start_ready` is 1.
- R2: A command is taken at a rising edge where `start_valid`, `start_ready` are 1 and `abort` is 0. `start_ready` is 1 only while no command runs.
- R3: A command whose count is 0 pulses `done` for one cycle right after the accepting edge. It leaves `phase_out` unchanged and the block stays ready.
- R4: For a nonzero count, `phase_out` shows the first state from the accepting edge onward. Every state is held for exactly HOLD_TICKS (default 32) prescaler ticks.
- R5: States are taken least-significant nibble first: bits [3:0], then [7:4], and so on up to [31:28].
- R6: After the state from bits [31:28], the next step restarts from bits [3:0] of the stored pattern.
- R7: When the last step's hold ends, `done` is 1 for exactly one cycle and `start_ready` returns to 1 in that same cycle. `phase_out` keeps the last state shown.
- R8: The prescaler tick period is `rate_div`+1 clocks, giving 1 to 65536 clocks. `rate_div` is sampled only when the prescaler restarts: at command acceptance and at each tick.
- R9: While a command runs, `start_valid` is ignored. The output sequence does not change and no command is queued.
- R10: `abort` returns the block to idle at the next edge. It takes priority over acceptance and completion, gives no `done`, and leaves `phase_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Idle, command can be taken |
| start_count | input | 16 | Number of steps |
| start_pattern | input | 32 | Eight 4-bit coil states, LSB nibble first |
| rate_div | input | 16 | Prescaler ratio minus one |
| abort | input | 1 | Drop running command, return to idle |
| phase_out | output | 4 | Coil phase lines |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The properties assume that `rst_n` is released synchronously and that inputs are never unknown after reset. They rely on `rate_div` and `start_count` being sampled only as R8 and R2 describe. The stimulus changes `rate_div` only inside a running hold period or between commands, and it asserts `abort` only for single cycles. Random commands keep counts to at most 20 steps and ratios to at most 4 clocks, so every step boundary is visited in bounded time. Directed cases cover the zero count, a mid-step ratio change, a start offered while busy, and an abort.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} stp_state_e;
endpackage

// File: rtl/stp_prescaler.sv
module stp_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_q, lim_d;
  logic             wrap;

  assign wrap = (cnt_q == lim_q);
  assign tick = run && !restart && wrap;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (restart) begin
      cnt_d = '0;
      lim_d = rate_div;
    end else if (run) begin
      if (wrap) begin
        cnt_d = '0;
        lim_d = rate_div;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/stp_pattern_reg.sv
module stp_pattern_reg #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 8,
  localparam int PAT_W = NIB_W * NIBS,
  localparam int IDX_W = $clog2(NIBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [PAT_W-1:0] pattern,
  output logic [NIB_W-1:0] next_nib
);
  logic [PAT_W-1:0] stored_q, stored_d;
  logic [PAT_W-1:0] work_q, work_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last     = (idx_q == IDX_W'(NIBS - 1));
  assign next_nib = last ? stored_q[NIB_W-1:0] : work_q[2*NIB_W-1:NIB_W];

  always_comb begin
    stored_d = stored_q;
    work_d   = work_q;
    idx_d    = idx_q;
    if (load) begin
      stored_d = pattern;
      work_d   = pattern;
      idx_d    = '0;
    end else if (advance) begin
      if (last) begin
        work_d = stored_q;
        idx_d  = '0;
      end else begin
        work_d = work_q >> NIB_W;
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
      work_q   <= '0;
      idx_q    <= '0;
    end else begin
      stored_q <= stored_d;
      work_q   <= work_d;
      idx_q    <= idx_d;
    end
  end
endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
  import stp_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int CNT_W      = 16,
  parameter int HOLD_TICKS = 32,
  localparam int HOLD_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [CNT_W-1:0] start_count,
  input  logic [NIB_W-1:0] first_nib,
  input  logic [NIB_W-1:0] next_nib,
  input  logic             abort,
  input  logic             tick,
  output logic             start_ready,
  output logic             pat_load,
  output logic             pat_advance,
  output logic             pre_restart,
  output logic             pre_run,
  output logic [NIB_W-1:0] phase_out,
  output logic             done
);
  stp_state_e       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [NIB_W-1:0] phase_q, phase_d;
  logic             done_q, done_d;
  logic             accept;
  logic             step_end;

  assign start_ready = (state_q == ST_IDLE);
  assign accept      = start_valid && start_ready && !abort;
  assign step_end    = tick && (hold_q == HOLD_W'(HOLD_TICKS - 1));
  assign pre_run     = (state_q == ST_RUN) && !abort;
  assign phase_out   = phase_q;
  assign done        = done_q;

  always_comb begin
    state_d     = state_q;
    remain_d    = remain_q;
    hold_d      = hold_q;
    phase_d     = phase_q;
    done_d      = 1'b0;
    pat_load    = 1'b0;
    pat_advance = 1'b0;
    pre_restart = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (start_count == '0) begin
            done_d = 1'b1;
          end else begin
            state_d     = ST_RUN;
            remain_d    = start_count;
            hold_d      = '0;
            phase_d     = first_nib;
            pat_load    = 1'b1;
            pre_restart = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (step_end) begin
          hold_d = '0;
          if (remain_q == CNT_W'(1)) begin
            state_d  = ST_IDLE;
            remain_d = '0;
            done_d   = 1'b1;
          end else begin
            remain_d    = remain_q - 1'b1;
            phase_d     = next_nib;
            pat_advance = 1'b1;
          end
        end else if (tick) begin
          hold_d = hold_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      hold_q   <= '0;
      phase_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      hold_q   <= hold_d;
      phase_q  <= phase_d;
      done_q   <= done_d;
    end
  end
endmodule

// File: rtl/stp_phase_seq.sv
module stp_phase_seq #(
  parameter int NIB_W      = 4,
  parameter int NIBS       = 8,
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 16,
  parameter int HOLD_TICKS = 32,
  localparam int PAT_W = NIB_W * NIBS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [CNT_W-1:0] start_count,
  input  logic [PAT_W-1:0] start_pattern,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             abort,
  output logic [NIB_W-1:0] phase_out,
  output logic             done
);
  logic             tick;
  logic             pat_load;
  logic             pat_advance;
  logic             pre_restart;
  logic             pre_run;
  logic [NIB_W-1:0] next_nib;

  stp_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (pre_restart),
    .run      (pre_run),
    .rate_div (rate_div),
    .tick     (tick)
  );

  stp_pattern_reg #(.NIB_W(NIB_W), .NIBS(NIBS)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pat_load),
    .advance  (pat_advance),
    .pattern  (start_pattern),
    .next_nib (next_nib)
  );

  stp_ctrl #(.NIB_W(NIB_W), .CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_count (start_count),
    .first_nib   (start_pattern[NIB_W-1:0]),
    .next_nib    (next_nib),
    .abort       (abort),
    .tick        (tick),
    .start_ready (start_ready),
    .pat_load    (pat_load),
    .pat_advance (pat_advance),
    .pre_restart (pre_restart),
    .pre_run     (pre_run),
    .phase_out   (phase_out),
    .done        (done)
  );
endmodule

// File: rtl/stp_phase_seq_chk.sv
module stp_phase_seq_chk #(
  parameter int NIB_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_valid,
  input logic             start_ready,
  input logic [CNT_W-1:0] start_count,
  input logic             abort,
  input logic [NIB_W-1:0] phase_out,
  input logic             done
);
  // R3: zero-count command finishes immediately with outputs held
  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && !abort && start_count == '0) |=> (done && $stable(phase_out) && start_ready));

  // R10: abort returns to idle with no done pulse
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (start_ready && !done && $stable(phase_out)));

  // R7: done coincides with the ready state
  assert_done_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);

  // R9: phase lines move only through an accepted start or a running command
  assert_phase_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_out) |-> $past(!start_ready || start_valid));

  // R2: done only follows a running command or a zero-count acceptance
  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!start_ready || (start_valid && start_count == '0)));

  // R1: outputs never unknown out of reset
  assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({phase_out, done, start_ready}));
endmodule

bind stp_phase_seq stp_phase_seq_chk #(.NIB_W(NIB_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .start_count (start_count),
  .abort       (abort),
  .phase_out   (phase_out),
  .done        (done)
);

// File: tb/stp_phase_seq_bench.sv
module stp_phase_seq_bench;
  localparam int HOLD = 32;

  logic        clk;
  logic        rst_n;
  logic        start_valid;
  logic        start_ready;
  logic [15:0] start_count;
  logic [31:0] start_pattern;
  logic [15:0] rate_div;
  logic        abort;
  logic [3:0]  phase_out;
  logic        done;

  int n_checks;
  int n_errors;
  bit finished;

  stp_phase_seq u_stp_phase_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_valid   (start_valid),
    .start_ready   (start_ready),
    .start_count   (start_count),
    .start_pattern (start_pattern),
    .rate_div      (rate_div),
    .abort         (abort),
    .phase_out     (phase_out),
    .done          (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [3:0] nib(input logic [31:0] pat, input int i);
    return pat[4*(i%8) +: 4];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance from offset m to target (cycles after accept edge), sampled at negedge
  task automatic goto(inout int m, input int target);
    if (target > m) begin
      repeat (target - m) @(posedge clk);
      @(negedge clk);
      m = target;
    end
  endtask

  task automatic offer(input int cnt, input logic [31:0] pat, input int dv);
    @(negedge clk);
    start_count   = 16'(cnt);
    start_pattern = pat;
    rate_div      = 16'(dv);
    start_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_valid   = 1'b0;
  endtask

  task automatic run_cmd(input int cnt, input logic [31:0] pat, input int dv, input bit poke);
    int m;
    int p;
    logic [3:0] prev;
    p    = dv + 1;
    prev = phase_out;
    offer(cnt, pat, dv);
    m = 0;
    if (cnt == 0) begin
      check("R3 done", done, 1'b1);
      check("R3 phase", phase_out, prev);
      check("R3 ready", start_ready, 1'b1);
      goto(m, 1);
      check("R3 pulse", done, 1'b0);
      return;
    end
    check("R2 busy", start_ready, 1'b0);
    check("R4 first", phase_out, nib(pat, 0));
    if (poke) begin
      goto(m, 2);
      start_count   = 16'd0;
      start_pattern = ~pat;
      start_valid   = 1'b1;
      goto(m, 5);
      check("R9 ready", start_ready, 1'b0);
      start_valid   = 1'b0;
    end
    for (int i = 0; i < cnt; i++) begin
      goto(m, i*HOLD*p + HOLD*p/2);
      check((i >= 8) ? "R6 wrap" : "R5 order", phase_out, nib(pat, i));
      if (i > 0) begin
        goto(m, i*HOLD*p);
        goto(m, i*HOLD*p + HOLD*p/2);
      end
    end
    if (cnt > 0) begin
      goto(m, (cnt-1)*HOLD*p + 1);
      goto(m, cnt*HOLD*p - 1);
      check("R4 hold", phase_out, nib(pat, cnt-1));
      check("R7 early", done, 1'b0);
      goto(m, cnt*HOLD*p);
      check("R7 done", done, 1'b1);
      check("R7 ready", start_ready, 1'b1);
      check("R7 last", phase_out, nib(pat, cnt-1));
      goto(m, cnt*HOLD*p + 1);
      check("R7 pulse", done, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    int m;
    logic [31:0] pat;
    int sawdone;
    pats[0] = 32'h84218421; pats[1] = 32'h12481248;
    pats[2] = 32'h9C639C63; pats[3] = 32'h36C936C9;
    pats[4] = 32'h98C46231; pats[5] = 32'h13264C89;
    n_checks = 0; n_errors = 0; finished = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_valid = 1'b0; start_count = '0;
    start_pattern = '0; rate_div = '0; abort = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phase", phase_out, 4'h0);
    check("R1 done", done, 1'b0);
    check("R1 ready", start_ready, 1'b1);

    // directed: half step, 10 steps (wrap), prescaler 1
    run_cmd(10, pats[4], 0, 1'b0);
    // zero count
    run_cmd(0, 32'hFFFF_FFFF, 2, 1'b0);
    // start offered while busy
    run_cmd(3, 32'h7654_3210, 0, 1'b1);

    // R8: ratio change mid-hold applies after current prescaler period
    pat = 32'hA5C3_1E2B;
    offer(2, pat, 7);
    m = 0;
    goto(m, 2);
    rate_div = 16'd0;
    goto(m, 38);
    check("R8 hold old", phase_out, nib(pat, 0));
    goto(m, 39);
    check("R8 step", phase_out, nib(pat, 1));
    goto(m, 70);
    check("R8 early", done, 1'b0);
    goto(m, 71);
    check("R8 done", done, 1'b1);

    // R10: abort in step 1
    pat = pats[2];
    offer(10, pat, 1);
    m = 0;
    goto(m, 100);
    check("R10 pre", phase_out, nib(pat, 1));
    abort = 1'b1;
    goto(m, 101);
    abort = 1'b0;
    check("R10 ready", start_ready, 1'b1);
    check("R10 phase", phase_out, nib(pat, 1));
    sawdone = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) sawdone = 1;
    end
    check("R10 nodone", sawdone, 0);
    check("R10 held", phase_out, nib(pat, 1));

    // random commands
    for (int t = 0; t < 12; t++) begin
      int c;
      int d;
      logic [31:0] pw;
      c  = int'($urandom_range(20, 1));
      d  = int'($urandom_range(3, 0));
      pw = ($urandom_range(1, 0) == 1) ? pats[$urandom_range(5, 0)] : $urandom;
      run_cmd(c, pw, d, 1'b0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule